// File: doc/BRIEF.md
# Decimal-capable 8-bit ALU with masked flag register

This block is the arithmetic and logic core of a small 8-bit processor datapath. One operation code selects among add with carry, subtract with borrow, compare, three bitwise operations, a bit test, and four one-bit shifts and rotates. Each takes the accumulator value, a memory operand and the carry input. The result, a four-bit flag vector and a four-bit update mask are all produced combinationally in the same cycle. The sequencer that owns instruction decode and bus timing supplies the operands and reads the result back.

When the decimal input is set, add and subtract treat each nibble as one decimal digit and correct the result directly. No separate adjust step is needed. A variant input chooses how the flags behave in decimal mode. In the legacy variant, N, V and Z follow the uncorrected binary result and only the carry follows the decimal result. In the corrected variant, every flag follows the decimal result, and the block signals that the sequencer must spend one extra cycle.

A small flag register holds N, V, Z and C. When the write strobe is high, the register loads only the bits that the operation's mask selects and keeps every other bit.

Top module: `bcd_alu`

## Requirements
- R1: Operation 0 (add) with decimal off gives result = (A + M + carry_i) mod 256. C is the carry out of bit 7. V is set when A and M have the same sign bit and the sign of the result differs from it. N is result bit 7 and Z is set when the result is zero. The mask is 1111.
- R2: Operation 1 (subtract) with decimal off gives result = (A − M − (1 − carry_i)) mod 256. C is 1 when no borrow occurred. V is set when A and M differ in sign and the result's sign differs from A. N and Z come from the result. The mask is 1111.
- R3: Operation 0 with decimal on adds the low digits together with carry_i. A sum above 9 is reduced by 10 and carries into the high digit. The high digit is treated the same way, and its carry becomes C. When both operands hold valid digits, each result nibble is 0 to 9.
- R4: Operation 1 with decimal on subtracts the low digits together with the borrow (1 − carry_i). A negative low digit gets 10 added and borrows from the high digit. A negative high digit gets 10 added. C equals the binary no-borrow of A − M − (1 − carry_i).
- R5: With decimal on and fixed_flags_i = 0, operations 0 and 1 take N, V and Z from the binary result of R1 or R2. The result and C are still decimal. extra_cycle_o is 0.
- R6: With decimal on and fixed_flags_i = 1, operations 0 and 1 take N and Z from the decimal result, and V applies the rule of R1 or R2 to the decimal result. In this case, and only in this case, extra_cycle_o is 1.
- R7: Operation 2 (compare) computes A − M with an implied carry of 1, ignoring carry_i and decimal_i. N is bit 7 of the difference, Z is set when A = M, and C is set when A ≥ M. result_o equals A. The mask is 1011, so the stored V is left as it was.
- R8: Operations 3, 4 and 5 give A AND M, A OR M and A XOR M. N and Z come from the result and the mask is 1010, so the stored V and C are left as they were.
- R9: Operation 6 (bit test) gives result A AND M. Z is set when A AND M is zero, N is M bit 7 and V is M bit 6. The mask is 1110.
- R10: Operation 7 shifts A left by one place, with a 0 entering bit 0 and A bit 7 going to C. Operation 8 shifts A right by one place, with a 0 entering bit 7, A bit 0 going to C, and N = 0. For both operations the mask is 1011.
- R11: Operation 9 rotates A left, with carry_i entering bit 0 and A bit 7 going to C. Operation 10 rotates A right, with carry_i entering bit 7 and A bit 0 going to C. N and Z come from the result and the mask is 1011.
- R12: Flag vectors are ordered [3]=N, [2]=V, [1]=Z, [0]=C. Reset clears the flag register. On a clock edge with flag_we_i high, each bit whose mask bit is 1 loads the new flag, and every other bit keeps its value. Operation codes 11 to 15 give result A with mask 0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the flag register |
| op_i | input | 4 | Operation code |
| a_i | input | 8 | Accumulator operand |
| m_i | input | 8 | Memory operand |
| carry_i | input | 1 | Carry in |
| decimal_i | input | 1 | Decimal mode for add and subtract |
| fixed_flags_i | input | 1 | 1 selects the corrected decimal flag variant |
| flag_we_i | input | 1 | Load the masked flags on this clock |
| result_o | output | 8 | Operation result |
| flag_o | output | 4 | New flags {N,V,Z,C}; only bits set in the mask are meaningful |
| upd_mask_o | output | 4 | Flags this operation updates |
| extra_cycle_o | output | 1 | Corrected decimal flags need one more cycle |
| flags_q_o | output | 4 | Stored flag register {N,V,Z,C} |

## Verification
Every path from operands to result and flags is combinational, so a fault in a digit correction or in a flag selection appears in result_o or flag_o in the same cycle the operands are applied. A wrong update mask, or a register that loads bits it should hold, only shows up one edge later in flags_q_o. For that reason the stored flags are compared after every edge against a running model, and an operation that leaves a flag alone must have no effect on that bit of the register. The legacy and corrected decimal variants differ only in N, V, Z and extra_cycle_o. They are told apart with sums where the binary and decimal results differ, such as 0x99 + 0x01.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;
  localparam int DW = 8;
  localparam int NW = DW / 2;
  localparam int FLAGS = 4;
  localparam int FN = 3;
  localparam int FV = 2;
  localparam int FZ = 1;
  localparam int FC = 0;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_CMP = 4'd2,
    OP_AND = 4'd3,
    OP_OR  = 4'd4,
    OP_XOR = 4'd5,
    OP_BIT = 4'd6,
    OP_SHL = 4'd7,
    OP_SHR = 4'd8,
    OP_ROL = 4'd9,
    OP_ROR = 4'd10
  } alu_op_e;

  // Two's complement overflow: both addends share a sign and the sum does not.
  function automatic logic signed_ovf(input logic a7, input logic b7, input logic r7);
    return (a7 == b7) && (r7 != a7);
  endfunction
endpackage

// File: rtl/bcd_alu_addsub.sv
module bcd_alu_addsub
  import bcd_alu_pkg::*;
(
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] m_i,
  input  logic          cin_i,
  input  logic          sub_i,
  output logic [DW-1:0] bin_o,
  output logic          bin_c_o,
  output logic [DW-1:0] dec_o,
  output logic          dec_c_o
);
  localparam int LW = NW + 2;

  logic [DW-1:0] m_eff;
  logic [DW:0]   sum;
  logic [LW-1:0] lo, hi;
  logic          lo_c, hi_c;

  assign m_eff   = sub_i ? ~m_i : m_i;
  assign sum     = {1'b0, a_i} + {1'b0, m_eff} + {{DW{1'b0}}, cin_i};
  assign bin_o   = sum[DW-1:0];
  assign bin_c_o = sum[DW];

  always_comb begin
    if (!sub_i) begin
      lo   = {2'b00, a_i[NW-1:0]} + {2'b00, m_i[NW-1:0]} + LW'(cin_i);
      lo_c = lo > LW'(9);
      if (lo_c) lo = lo + LW'(6);
      hi   = {2'b00, a_i[DW-1:NW]} + {2'b00, m_i[DW-1:NW]} + LW'(lo_c);
      hi_c = hi > LW'(9);
      if (hi_c) hi = hi + LW'(6);
      dec_c_o = hi_c;
    end else begin
      lo   = {2'b00, a_i[NW-1:0]} - {2'b00, m_i[NW-1:0]} - LW'(!cin_i);
      lo_c = lo[LW-1];
      if (lo_c) lo = lo - LW'(6);
      hi   = {2'b00, a_i[DW-1:NW]} - {2'b00, m_i[DW-1:NW]} - LW'(lo_c);
      hi_c = hi[LW-1];
      if (hi_c) hi = hi - LW'(6);
      dec_c_o = sum[DW];
    end
    dec_o = {hi[NW-1:0], lo[NW-1:0]};
  end
endmodule

// File: rtl/bcd_alu_bitops.sv
module bcd_alu_bitops
  import bcd_alu_pkg::*;
(
  input  alu_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] m_i,
  input  logic          cin_i,
  output logic [DW-1:0] res_o,
  output logic          n_o,
  output logic          v_o,
  output logic          c_o
);
  always_comb begin
    res_o = a_i;
    v_o   = 1'b0;
    c_o   = 1'b0;
    case (op_i)
      OP_AND: res_o = a_i & m_i;
      OP_OR:  res_o = a_i | m_i;
      OP_XOR: res_o = a_i ^ m_i;
      OP_BIT: begin res_o = a_i & m_i; v_o = m_i[DW-2]; end
      OP_SHL: begin res_o = {a_i[DW-2:0], 1'b0};  c_o = a_i[DW-1]; end
      OP_SHR: begin res_o = {1'b0, a_i[DW-1:1]};  c_o = a_i[0];    end
      OP_ROL: begin res_o = {a_i[DW-2:0], cin_i}; c_o = a_i[DW-1]; end
      OP_ROR: begin res_o = {cin_i, a_i[DW-1:1]}; c_o = a_i[0];    end
      default: res_o = a_i;
    endcase
    n_o = (op_i == OP_BIT) ? m_i[DW-1] : res_o[DW-1];
  end
endmodule

// File: rtl/bcd_alu_flagreg.sv
module bcd_alu_flagreg
  import bcd_alu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [FLAGS-1:0] mask_i,
  input  logic [FLAGS-1:0] nxt_i,
  output logic [FLAGS-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= '0;
    else if (we_i) q_o <= (q_o & ~mask_i) | (nxt_i & mask_i);
  end

  a_r12_masked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> ((q_o ^ $past(q_o)) & ~$past(mask_i)) == '0);

  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/bcd_alu.sv
module bcd_alu
  import bcd_alu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       op_i,
  input  logic [DW-1:0]    a_i,
  input  logic [DW-1:0]    m_i,
  input  logic             carry_i,
  input  logic             decimal_i,
  input  logic             fixed_flags_i,
  input  logic             flag_we_i,
  output logic [DW-1:0]    result_o,
  output logic [FLAGS-1:0] flag_o,
  output logic [FLAGS-1:0] upd_mask_o,
  output logic             extra_cycle_o,
  output logic [FLAGS-1:0] flags_q_o
);
  alu_op_e       op;
  logic          is_sub, is_arith, use_dec, as_cin, m7_eff;
  logic [DW-1:0] bin_sum, dec_sum, bit_res;
  logic          bin_c, dec_c, bit_n, bit_v, bit_c;
  logic          fn, fv, fz, fc;

  assign op       = alu_op_e'(op_i);
  assign is_sub   = (op == OP_SUB) || (op == OP_CMP);
  assign is_arith = (op == OP_ADD) || (op == OP_SUB);
  assign use_dec  = is_arith && decimal_i;
  assign as_cin   = (op == OP_CMP) ? 1'b1 : carry_i;
  assign m7_eff   = is_sub ? ~m_i[DW-1] : m_i[DW-1];

  bcd_alu_addsub u_addsub (
    .a_i(a_i), .m_i(m_i), .cin_i(as_cin), .sub_i(is_sub),
    .bin_o(bin_sum), .bin_c_o(bin_c), .dec_o(dec_sum), .dec_c_o(dec_c)
  );

  bcd_alu_bitops u_bitops (
    .op_i(op), .a_i(a_i), .m_i(m_i), .cin_i(carry_i),
    .res_o(bit_res), .n_o(bit_n), .v_o(bit_v), .c_o(bit_c)
  );

  always_comb begin
    result_o   = a_i;
    upd_mask_o = 4'b0000;
    fn = 1'b0; fv = 1'b0; fz = 1'b0; fc = 1'b0;
    case (op)
      OP_ADD, OP_SUB: begin
        upd_mask_o = 4'b1111;
        result_o   = use_dec ? dec_sum : bin_sum;
        fc         = use_dec ? dec_c : bin_c;
        if (use_dec && !fixed_flags_i) begin
          fn = bin_sum[DW-1];
          fz = (bin_sum == '0);
          fv = signed_ovf(a_i[DW-1], m7_eff, bin_sum[DW-1]);
        end else begin
          fn = result_o[DW-1];
          fz = (result_o == '0);
          fv = signed_ovf(a_i[DW-1], m7_eff, result_o[DW-1]);
        end
      end
      OP_CMP: begin
        upd_mask_o = 4'b1011;
        fn = bin_sum[DW-1];
        fz = (bin_sum == '0);
        fc = bin_c;
      end
      OP_AND, OP_OR, OP_XOR: begin
        upd_mask_o = 4'b1010;
        result_o = bit_res; fn = bit_n; fz = (bit_res == '0);
      end
      OP_BIT: begin
        upd_mask_o = 4'b1110;
        result_o = bit_res; fn = bit_n; fv = bit_v; fz = (bit_res == '0);
      end
      OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
        upd_mask_o = 4'b1011;
        result_o = bit_res; fn = bit_n; fz = (bit_res == '0); fc = bit_c;
      end
      default: begin
        result_o   = a_i;
        upd_mask_o = 4'b0000;
      end
    endcase
  end

  assign flag_o        = {fn, fv, fz, fc};
  assign extra_cycle_o = use_dec && fixed_flags_i;

  bcd_alu_flagreg u_flags (
    .clk(clk), .rst_n(rst_n), .we_i(flag_we_i),
    .mask_i(upd_mask_o), .nxt_i(flag_o), .q_o(flags_q_o)
  );

  // R5: legacy decimal add takes Z from the uncorrected binary sum
  a_r5_legacy_z: assert property (@(posedge clk) disable iff (!rst_n)
    (decimal_i && !fixed_flags_i && op == OP_ADD) |-> (flag_o[FZ] == (bin_sum == '0)));

  a_r6_fixed_z: assert property (@(posedge clk) disable iff (!rst_n)
    (decimal_i && fixed_flags_i && is_arith) |-> (flag_o[FZ] == (result_o == '0)));

  a_r6_extra_full_mask: assert property (@(posedge clk) disable iff (!rst_n)
    extra_cycle_o |-> (upd_mask_o == 4'b1111 && decimal_i));

  a_r3_digits_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (decimal_i && op == OP_ADD && a_i[7:4] < 4'd10 && a_i[3:0] < 4'd10 &&
     m_i[7:4] < 4'd10 && m_i[3:0] < 4'd10)
    |-> (result_o[7:4] < 4'd10 && result_o[3:0] < 4'd10));

  a_r10_shr_top_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SHR) |-> (!result_o[DW-1] && !flag_o[FN]));
endmodule

// File: tb/bcd_alu_tb.sv
`timescale 1ns/1ps
module bcd_alu_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] a_i = '0, m_i = '0;
  logic       carry_i = 1'b0, decimal_i = 1'b0, fixed_flags_i = 1'b0, flag_we_i = 1'b0;
  logic [7:0] result_o;
  logic [3:0] flag_o, upd_mask_o, flags_q_o;
  logic       extra_cycle_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [3:0] shadow = 4'b0000;

  always #10 clk = ~clk;

  bcd_alu u_dut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .m_i(m_i),
    .carry_i(carry_i), .decimal_i(decimal_i), .fixed_flags_i(fixed_flags_i),
    .flag_we_i(flag_we_i), .result_o(result_o), .flag_o(flag_o),
    .upd_mask_o(upd_mask_o), .extra_cycle_o(extra_cycle_o), .flags_q_o(flags_q_o)
  );

  // returns {extra, mask[3:0], flags[3:0], result[7:0]}
  function automatic logic [16:0] model(int op, int a, int m, int c, int d, int fx);
    int res, n, v, z, cf, mask, ex, s, bres, lo, hi, k;
    res = a; n = 0; v = 0; z = 0; cf = 0; mask = 0; ex = 0;
    case (op)
      0, 1: begin
        mask = 15;
        if (op == 0) s = a + m + c; else s = a - m - (1 - c);
        bres = s & 255;
        if (op == 0) cf = (s > 255); else cf = (s >= 0);
        res = bres;
        if (d != 0) begin
          k = 0;
          if (op == 0) begin
            lo = (a & 15) + (m & 15) + c;
            if (lo > 9) begin lo = lo - 10; k = 1; end
            hi = (a >> 4) + (m >> 4) + k;
            cf = 0;
            if (hi > 9) begin hi = hi - 10; cf = 1; end
          end else begin
            lo = (a & 15) - (m & 15) - (1 - c);
            if (lo < 0) begin lo = lo + 10; k = 1; end
            hi = (a >> 4) - (m >> 4) - k;
            if (hi < 0) hi = hi + 10;
          end
          res = ((hi & 15) << 4) | (lo & 15);
          ex = fx;
        end
        begin
          int fr;
          fr = (d != 0 && fx == 0) ? bres : res;
          n = (fr >> 7) & 1;
          z = (fr == 0);
          if (op == 0) v = (((a ^ fr) & (m ^ fr) & 128) != 0);
          else         v = (((a ^ m) & (a ^ fr) & 128) != 0);
        end
      end
      2: begin mask = 11; s = (a - m) & 255; n = (s >> 7) & 1; z = (a == m); cf = (a >= m); res = a; end
      3, 4, 5: begin
        mask = 10;
        res = (op == 3) ? (a & m) : (op == 4) ? (a | m) : (a ^ m);
        n = (res >> 7) & 1; z = (res == 0);
      end
      6: begin mask = 14; res = a & m; n = (m >> 7) & 1; v = (m >> 6) & 1; z = (res == 0); end
      7, 8, 9, 10: begin
        mask = 11;
        if (op == 7)      begin res = (a << 1) & 255;       cf = (a >> 7) & 1; end
        else if (op == 8) begin res = a >> 1;               cf = a & 1; end
        else if (op == 9) begin res = ((a << 1) | c) & 255; cf = (a >> 7) & 1; end
        else              begin res = (a >> 1) | (c << 7);  cf = a & 1; end
        n = (res >> 7) & 1; z = (res == 0);
      end
      default: begin res = a; mask = 0; end
    endcase
    return {ex[0], mask[3:0], n[0], v[0], z[0], cf[0], res[7:0]};
  endfunction

  function automatic string tag_of(int op, int d, int fx);
    case (op)
      0: return (d == 0) ? "R1" : (fx != 0) ? "R6" : "R5";
      1: return (d == 0) ? "R2" : (fx != 0) ? "R6" : "R5";
      2: return "R7";
      3, 4, 5: return "R8";
      6: return "R9";
      7, 8: return "R10";
      9, 10: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic run(string tag, int op, int a, int m, int c, int d, int fx, int we);
    logic [16:0] e;
    @(negedge clk);
    check("R12", flags_q_o, shadow, "stored flags");
    op_i = op[3:0]; a_i = a[7:0]; m_i = m[7:0]; carry_i = c[0];
    decimal_i = d[0]; fixed_flags_i = fx[0]; flag_we_i = we[0];
    #2;
    e = model(op, a, m, c, d, fx);
    check(tag, result_o, e[7:0], "result");
    check(tag, flag_o & e[15:12], e[11:8] & e[15:12], "masked flags");
    check(tag, upd_mask_o, e[15:12], "update mask");
    check(tag, extra_cycle_o, e[16], "extra cycle");
    if (we != 0) shadow = (shadow & ~e[15:12]) | (e[11:8] & e[15:12]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R12 watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240511));
    repeat (3) @(negedge clk);
    check("R12", flags_q_o, 0, "reset flags");
    rst_n = 1'b1;

    // directed corners
    run("R1", 0, 8'h7F, 8'h01, 0, 0, 0, 1);   // N=1 V=1
    run("R8", 3, 8'hF0, 8'h3C, 0, 0, 0, 1);   // V and C held
    run("R2", 1, 8'h80, 8'h01, 1, 0, 0, 1);   // V=1
    run("R3", 0, 8'h58, 8'h46, 1, 1, 0, 1);   // 0x05, C=1
    run("R3", 0, 8'h99, 8'h01, 0, 1, 1, 1);   // 0x00
    run("R5", 0, 8'h99, 8'h01, 0, 1, 0, 1);   // Z from 0x9A
    run("R6", 0, 8'h99, 8'h01, 0, 1, 1, 1);   // Z from 0x00
    run("R4", 1, 8'h00, 8'h01, 1, 1, 0, 1);   // 0x99, C=0
    run("R4", 1, 8'h42, 8'h17, 1, 1, 1, 1);   // 0x25
    run("R7", 2, 8'h33, 8'h33, 0, 1, 0, 1);   // equal, decimal ignored
    run("R7", 2, 8'h10, 8'h20, 1, 0, 0, 1);
    run("R9", 6, 8'h0F, 8'hC0, 0, 0, 0, 1);
    run("R10", 7, 8'h80, 8'h00, 0, 0, 0, 1);
    run("R10", 8, 8'h81, 8'h00, 1, 0, 0, 1);
    run("R11", 9, 8'h80, 8'h00, 1, 0, 0, 1);
    run("R11", 10, 8'h01, 8'h00, 1, 0, 0, 1);
    run("R12", 13, 8'hAA, 8'h55, 1, 1, 1, 1); // mask 0, nothing loads
    run("R12", 0, 8'hFF, 8'h01, 0, 0, 0, 0);  // strobe low
    run("R12", 4, 8'h00, 8'h00, 0, 0, 0, 1);

    for (int i = 0; i < 3000; i++) begin
      int op, a, m, c, d, fx, we;
      op = $urandom_range(0, 15);
      c  = $urandom_range(0, 1);
      d  = $urandom_range(0, 1);
      fx = $urandom_range(0, 1);
      we = ($urandom_range(0, 7) != 0) ? 1 : 0;
      if ($urandom_range(0, 1) == 1) begin
        a = ($urandom_range(0, 9) << 4) | $urandom_range(0, 9);
        m = ($urandom_range(0, 9) << 4) | $urandom_range(0, 9);
      end else begin
        a = $urandom_range(0, 255);
        m = $urandom_range(0, 255);
      end
      run(tag_of(op, d, fx), op, a, m, c, d, fx, we);
    end

    @(negedge clk);
    check("R12", flags_q_o, shadow, "final stored flags");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule